// File: doc/BRIEF.md
# System Clock Divider Switch Sequencer

This block changes the system clock division ratio while the chip is running. Software posts a request together with a 3-bit ratio code. The sequencer first looks up the actual divisor. That lookup depends on which source clock is selected: the 64 MHz internal oscillator uses power-of-two steps, and the 48 MHz external source uses steps of 1, 2, 3 and then 3·2ⁿ. As a result, both sources reach roughly the same set of target frequencies.

The new divisor is loaded only when a divided period of the old ratio ends. The block then waits a fixed number of source cycles and reports completion. It raises an end-of-sequence flag and, when enabled, an interrupt.

Software may withdraw a request at any point before the flag rises. The slowest settings are gated by an auxiliary enable. A request for one of them while that enable is low is turned away immediately. The divided clock leaves the block as a one-cycle enable pulse on the source clock.

Top module: `sysclk_ratio_seq`

## Requirements
- R1: After reset, the status is 00, the request bit is 0, the end flag is 0, the interrupt is 0, and the ratio is 1, so `clk_en` is high on every cycle.
- R2: With `src_ext`=0, codes 000, 001, 010, 011, 100, 101 and 110 give a `clk_en` period of 1, 2, 4, 8, 16, 32 and 64 source cycles.
- R3: With `src_ext`=1, codes 000, 001, 010, 011, 100, 101 and 110 give a `clk_en` period of 1, 2, 3, 6, 12, 24 and 48 source cycles.
- R4: Code 111 is reserved and selects a ratio of 1.
- R5: The new ratio is loaded on the cycle that ends a full period of the old ratio. No `clk_en` period is shorter than the lesser of the old and new ratios.
- R6: An accepted request moves the status to 01 (busy) and sets the request bit. The block then aligns to the old period's end and settles for 4 source cycles. After that, the status is 10 (done), the request bit is 0, and the end flag is 1.
- R7: A `req_clear` while the status is 01 returns the status to 00 on the next cycle and clears the request bit. The end flag is not set. A cancel before the alignment point leaves the old ratio in force.
- R8: A request for a gated code while `aux_en` is 0 is rejected. The status goes to 00, the ratio does not change, and no flag is raised. Gated codes are 011 through 110 for either source, plus 001 when `src_ext`=1.
- R9: A `req_set` while the status is 01 is ignored. The switch in progress completes with its original code.
- R10: `flag_clr` clears the end flag on the next cycle. Setting the flag takes priority if both happen in the same cycle.
- R11: `irq` is 1 exactly when the end flag is 1 and `irq_en` is 1.
- R12: The status never takes the reserved value 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| req_set | input | 1 | Software writes 1 to the request bit, with `req_code` |
| req_clear | input | 1 | Software writes 0 to the request bit (cancel) |
| req_code | input | 3 | Ratio code of the request |
| src_ext | input | 1 | 0: 64 MHz internal source, 1: 48 MHz external source |
| aux_en | input | 1 | Permits the low-frequency settings |
| flag_clr | input | 1 | Write-1-to-clear of the end flag |
| irq_en | input | 1 | End-of-sequence interrupt enable |
| req_busy | output | 1 | Request bit readback |
| status | output | 2 | 00 idle, 01 busy, 10 done |
| eos_flag | output | 1 | End-of-sequence flag |
| irq | output | 1 | Interrupt request |
| clk_en | output | 1 | One-cycle divided-clock enable pulse |

## Verification
Some properties are checked on every cycle: the status never shows the reserved code, an interrupt never appears without the flag, and a cancel, a rejected request or a flag clear each reach their required state one cycle later. A request made while busy never drops the status back to idle, and the flag only rises together with the done status.

Other properties need the bench's scenarios, which compare every output with a behavioural model on every cycle. These are the divisor tables for both sources, the reserved code, the alignment of a ratio change to the old period's end, the four-cycle settle, and the survival of the old ratio after a cancel or a rejection.

// File: rtl/sysclk_ratio_pkg.sv
package sysclk_ratio_pkg;

    parameter int CODE_W     = 3;
    parameter int RATIO_W    = 7;
    parameter int SETTLE_CYC = 4;

    localparam int NCODES = 1 << CODE_W;
    localparam int SC_W   = $clog2(SETTLE_CYC + 1);
    localparam logic [CODE_W-1:0] CODE_RSVD = '1;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_ALIGN  = 2'd1,
        PH_SETTLE = 2'd2,
        PH_DONE   = 2'd3
    } seq_phase_e;

    typedef enum logic [1:0] {
        SW_IDLE = 2'b00,
        SW_BUSY = 2'b01,
        SW_DONE = 2'b10
    } sw_status_e;

    typedef struct packed {
        logic [RATIO_W-1:0] ratio;
        logic               allowed;
    } ratio_req_t;

    // Divisor for a code; the external source uses the 1,2,3,6,12.. ladder.
    function automatic logic [RATIO_W-1:0] ratio_of(input logic [CODE_W-1:0] code,
                                                    input logic ext);
        logic [RATIO_W-1:0] r;
        if (code == CODE_RSVD || code == '0)
            r = RATIO_W'(1);
        else if (!ext)
            r = RATIO_W'(1) << code;
        else if (code == CODE_W'(1))
            r = RATIO_W'(2);
        else
            r = RATIO_W'(3) << (code - CODE_W'(2));
        return r;
    endfunction

    // Low-frequency settings that need the auxiliary enable.
    function automatic logic needs_aux(input logic [CODE_W-1:0] code, input logic ext);
        return (code >= CODE_W'(3) && code <= CODE_W'(6)) || (code == CODE_W'(1) && ext);
    endfunction

endpackage

// File: rtl/sysclk_ratio_lut.sv
module sysclk_ratio_lut
    import sysclk_ratio_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic              src_ext,
    input  logic              aux_en,
    output ratio_req_t        sel
);
    logic [RATIO_W-1:0] tbl_int [NCODES];
    logic [RATIO_W-1:0] tbl_ext [NCODES];
    logic               gate_ext [NCODES];
    logic               gate_int [NCODES];

    for (genvar g = 0; g < NCODES; g++) begin : g_tbl
        assign tbl_int[g]  = ratio_of(CODE_W'(g), 1'b0);
        assign tbl_ext[g]  = ratio_of(CODE_W'(g), 1'b1);
        assign gate_int[g] = needs_aux(CODE_W'(g), 1'b0);
        assign gate_ext[g] = needs_aux(CODE_W'(g), 1'b1);
    end

    always_comb begin
        if (src_ext) begin
            sel.ratio   = tbl_ext[code];
            sel.allowed = aux_en || !gate_ext[code];
        end else begin
            sel.ratio   = tbl_int[code];
            sel.allowed = aux_en || !gate_int[code];
        end
    end
endmodule

// File: rtl/sysclk_ratio_tick.sv
module sysclk_ratio_tick
    import sysclk_ratio_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [RATIO_W-1:0] ratio,
    output logic               tick
);
    logic [RATIO_W-1:0] cnt;

    assign tick = (cnt >= ratio - RATIO_W'(1));

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + RATIO_W'(1);
    end
endmodule

// File: rtl/sysclk_ratio_fsm.sv
module sysclk_ratio_fsm
    import sysclk_ratio_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_set,
    input  logic               req_clear,
    input  logic               flag_clr,
    input  ratio_req_t         sel,
    input  logic               tick,
    output logic [RATIO_W-1:0] ratio_cur,
    output seq_phase_e         phase,
    output logic               flag
);
    logic [RATIO_W-1:0] ratio_pend;
    logic [SC_W-1:0]    settle_cnt;
    logic               finish;

    assign finish = (phase == PH_SETTLE) && !req_clear &&
                    (settle_cnt == SC_W'(SETTLE_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_IDLE;
            ratio_cur  <= RATIO_W'(1);
            ratio_pend <= RATIO_W'(1);
            settle_cnt <= '0;
        end else begin
            unique case (phase)
                PH_IDLE, PH_DONE: begin
                    if (req_set) begin
                        if (sel.allowed) begin
                            phase      <= PH_ALIGN;
                            ratio_pend <= sel.ratio;
                        end else begin
                            phase <= PH_IDLE;
                        end
                    end
                end
                PH_ALIGN: begin
                    if (req_clear) begin
                        phase <= PH_IDLE;
                    end else if (tick) begin
                        ratio_cur  <= ratio_pend;
                        settle_cnt <= '0;
                        phase      <= PH_SETTLE;
                    end
                end
                PH_SETTLE: begin
                    if (req_clear)   phase <= PH_IDLE;
                    else if (finish) phase <= PH_DONE;
                    else             settle_cnt <= settle_cnt + SC_W'(1);
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           flag <= 1'b0;
        else if (finish)   flag <= 1'b1;
        else if (flag_clr) flag <= 1'b0;
    end
endmodule

// File: rtl/sysclk_ratio_seq.sv
module sysclk_ratio_seq
    import sysclk_ratio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_set,
    input  logic              req_clear,
    input  logic [CODE_W-1:0] req_code,
    input  logic              src_ext,
    input  logic              aux_en,
    input  logic              flag_clr,
    input  logic              irq_en,
    output logic              req_busy,
    output logic [1:0]        status,
    output logic              eos_flag,
    output logic              irq,
    output logic              clk_en
);
    ratio_req_t         sel;
    logic [RATIO_W-1:0] ratio_cur;
    seq_phase_e         phase;
    logic               tick;
    sw_status_e         st;

    sysclk_ratio_lut u_lut (
        .code    (req_code),
        .src_ext (src_ext),
        .aux_en  (aux_en),
        .sel     (sel)
    );

    sysclk_ratio_tick u_tick (
        .clk   (clk),
        .rst   (rst),
        .ratio (ratio_cur),
        .tick  (tick)
    );

    sysclk_ratio_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_set   (req_set),
        .req_clear (req_clear),
        .flag_clr  (flag_clr),
        .sel       (sel),
        .tick      (tick),
        .ratio_cur (ratio_cur),
        .phase     (phase),
        .flag      (eos_flag)
    );

    always_comb begin
        unique case (phase)
            PH_ALIGN, PH_SETTLE: st = SW_BUSY;
            PH_DONE:             st = SW_DONE;
            default:             st = SW_IDLE;
        endcase
    end

    assign status   = st;
    assign req_busy = (phase == PH_ALIGN) || (phase == PH_SETTLE);
    assign irq      = eos_flag && irq_en;
    assign clk_en   = tick;
endmodule

// File: rtl/sysclk_ratio_chk.sv
module sysclk_ratio_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_set,
    input logic       req_clear,
    input logic [2:0] req_code,
    input logic       src_ext,
    input logic       aux_en,
    input logic       flag_clr,
    input logic [1:0] status,
    input logic       req_busy,
    input logic       eos_flag,
    input logic       irq
);
    logic gated;
    assign gated = (req_code >= 3'd3 && req_code <= 3'd6) || (req_code == 3'd1 && src_ext);

    p_status_legal_r12: assert property (@(posedge clk) disable iff (rst)
        status != 2'b11);

    p_irq_needs_flag_r11: assert property (@(posedge clk) disable iff (rst)
        irq |-> eos_flag);

    p_cancel_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (status == 2'b01 && req_clear) |=> (status == 2'b00 && !req_busy));

    p_busy_ignores_set_r9: assert property (@(posedge clk) disable iff (rst)
        (status == 2'b01 && req_set && !req_clear) |=> (status != 2'b00));

    p_reject_gated_r8: assert property (@(posedge clk) disable iff (rst)
        (status != 2'b01 && req_set && gated && !aux_en) |=> (status == 2'b00));

    p_flag_with_done_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(eos_flag) |-> (status == 2'b10 && !req_busy));

    p_flag_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (eos_flag && flag_clr && status != 2'b01) |=> !eos_flag);
endmodule

bind sysclk_ratio_seq sysclk_ratio_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_set   (req_set),
    .req_clear (req_clear),
    .req_code  (req_code),
    .src_ext   (src_ext),
    .aux_en    (aux_en),
    .flag_clr  (flag_clr),
    .status    (status),
    .req_busy  (req_busy),
    .eos_flag  (eos_flag),
    .irq       (irq)
);

// File: tb/test_sysclk_ratio_seq.sv
module test_sysclk_ratio_seq;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_set = 0, req_clear = 0, src_ext = 0, aux_en = 0, flag_clr = 0, irq_en = 0;
    logic [2:0] req_code = 3'd0;
    logic       req_busy, eos_flag, irq, clk_en;
    logic [1:0] status;

    int checks = 0, fails = 0;
    bit cmp_on = 0, finished = 0;

    always #(CLK_P/2) clk = ~clk;

    sysclk_ratio_seq i_sysclk_ratio_seq (
        .clk(clk), .rst(rst), .req_set(req_set), .req_clear(req_clear),
        .req_code(req_code), .src_ext(src_ext), .aux_en(aux_en),
        .flag_clr(flag_clr), .irq_en(irq_en), .req_busy(req_busy),
        .status(status), .eos_flag(eos_flag), .irq(irq), .clk_en(clk_en)
    );

    // ---------------- behavioural reference ----------------
    int m_mode;   // 0 idle, 1 wait for period end, 2 settling, 3 done
    int m_div, m_next, m_pos, m_wait;
    bit m_flag;

    function automatic int ref_div(int code, bit ext);
        if (ext) case (code)
            1: return 2;  2: return 3;  3: return 6;  4: return 12;
            5: return 24; 6: return 48; default: return 1;
        endcase
        case (code)
            1: return 2;  2: return 4;  3: return 8;  4: return 16;
            5: return 32; 6: return 64; default: return 1;
        endcase
    endfunction

    function automatic bit ref_gated(int code, bit ext);
        return (code >= 3 && code <= 6) || (code == 1 && ext);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_div = 1; m_next = 1; m_pos = 0; m_wait = 0; m_flag = 0;
        end else begin
            bit edge_now, done_now;
            edge_now = (m_pos == m_div - 1);
            done_now = 0;
            m_pos = edge_now ? 0 : m_pos + 1;
            if (m_mode == 0 || m_mode == 3) begin
                if (req_set) begin
                    if (ref_gated(req_code, src_ext) && !aux_en) m_mode = 0;
                    else begin m_mode = 1; m_next = ref_div(req_code, src_ext); end
                end
            end else if (m_mode == 1) begin
                if (req_clear) m_mode = 0;
                else if (edge_now) begin m_div = m_next; m_mode = 2; m_wait = 0; end
            end else begin
                if (req_clear) m_mode = 0;
                else if (m_wait == 3) begin m_mode = 3; done_now = 1; end
                else m_wait++;
            end
            if (done_now) m_flag = 1;
            else if (flag_clr) m_flag = 0;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && !rst) begin
            int es;
            es = (m_mode == 1 || m_mode == 2) ? 1 : (m_mode == 3 ? 2 : 0);
            chk(clk_en == (m_pos == m_div - 1), "R5 clk_en vs model", clk_en, m_pos == m_div - 1);
            chk(status == es, "R6 status vs model", status, es);
            chk(req_busy == (es == 1), "R6 request bit vs model", req_busy, es == 1);
            chk(eos_flag == m_flag, "R10 flag vs model", eos_flag, m_flag);
            chk(irq == (m_flag && irq_en), "R11 irq vs model", irq, m_flag && irq_en);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic drive_next();
        @(negedge clk); #2;
    endtask

    task automatic request(input int code);
        drive_next(); req_set = 1; req_code = 3'(code);
        drive_next(); req_set = 0;
    endtask

    task automatic cancel();
        drive_next(); req_clear = 1;
        drive_next(); req_clear = 0;
    endtask

    task automatic clear_flag();
        drive_next(); flag_clr = 1;
        drive_next(); flag_clr = 0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (status != 2'b10 && n < 400) begin @(negedge clk); #1; n++; end
        chk(status == 2'b10, tag, status, 2);
    endtask

    task automatic measure(input int exp, input string tag);
        int n = 0, g = 0;
        @(negedge clk); #1;
        while (!clk_en && n < 200) begin @(negedge clk); #1; n++; end
        do begin @(negedge clk); #1; g++; end while (!clk_en && g < 200);
        chk(g == exp, tag, g, exp);
    endtask

    task automatic switch_to(input int code, input bit ext, input int exp, input string tag);
        src_ext = ext;
        request(code);
        wait_done({tag, " done"});
        chk(eos_flag && !req_busy, "R6 flag set, request bit cleared", eos_flag, 1);
        measure(exp, tag);
        clear_flag();
        @(negedge clk); #1;
        chk(!eos_flag, "R10 flag cleared", eos_flag, 0);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        #2 rst = 0;
        cmp_on = 1;
        @(negedge clk); #1;
        chk(status == 2'b00, "R1 reset status", status, 0);
        chk(!req_busy && !eos_flag && !irq, "R1 reset bits", req_busy + eos_flag + irq, 0);
        chk(clk_en, "R1 ratio 1 after reset", clk_en, 1);

        irq_en = 1; aux_en = 1;
        for (int c = 0; c < 7; c++) switch_to(c, 0, ref_div(c, 0), "R2 internal period");
        switch_to(7, 0, 1, "R4 reserved code");
        for (int c = 0; c < 7; c++) switch_to(c, 1, ref_div(c, 1), "R3 external period");

        // R8: gated settings refused without the auxiliary enable
        switch_to(2, 1, 3, "R3 external period");
        aux_en = 0;
        request(1);
        chk(status == 2'b00 && !eos_flag, "R8 ext code 001 rejected", status, 0);
        measure(3, "R8 ratio kept");
        src_ext = 0;
        request(4);
        chk(status == 2'b00 && !eos_flag, "R8 int code 100 rejected", status, 0);
        measure(3, "R8 ratio kept");
        switch_to(2, 0, 4, "R8 ungated code allowed");

        // R7: cancel before the alignment point keeps the old ratio
        aux_en = 1;
        switch_to(6, 0, 64, "R2 internal period");
        request(0);
        chk(status == 2'b01 && req_busy, "R6 busy after request", status, 1);
        cancel();
        chk(status == 2'b00 && !req_busy, "R7 cancel returns idle", status, 0);
        repeat (80) @(negedge clk);
        #1 chk(!eos_flag, "R7 no flag after cancel", eos_flag, 0);
        measure(64, "R7 old ratio kept");

        // R9: a second request while busy is ignored
        request(1);
        request(0);
        wait_done("R9 done");
        measure(2, "R9 original code applied");

        // R11: interrupt follows the enable
        irq_en = 0;
        @(negedge clk); #1;
        chk(!irq && eos_flag, "R11 irq masked", irq, 0);
        irq_en = 1;
        @(negedge clk); #1;
        chk(irq, "R11 irq enabled", irq, 1);
        clear_flag();

        // R5: change from 8 to 2 with a cancel-free run, compared each cycle
        switch_to(3, 0, 8, "R5 pre");
        switch_to(1, 0, 2, "R5 post");

        cmp_on = 0;
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule